// File: doc/BRIEF.md
# PLL Lock-Change Interrupt Controller

This block is the control and status register slice of a clock generator. It holds the bits that power the PLL up, choose whether the output clock comes from the VCO (divided by two), and arm an interrupt. It also watches the PLL's lock indication. The lock input is asynchronous, so it is brought into the bus clock domain through a flop chain before any edge detection.

In automatic mode, every change of lock sets a sticky flag, whether lock was gained or lost. The flag reaches the CPU interrupt line only when the interrupt enable is set. Software then reads the lock bit to learn which way the change went, and clears the flag by writing a one to it. The analog PLL and the glitch-free clock switch sit outside the block. They see only the enable and select outputs.

Top module: `pll_lockirq_ctrl`

## Requirements
- R1: After reset, every control bit reads 0, the flag and lock bits read 0, and `pll_en`, `vco_sel` and `irq_req` are 0.
- R2: The control word is at address 0. Bit 0 is PLL-on, bit 1 is source select, bit 2 is interrupt enable and bit 3 is automatic mode. Written values read back unchanged, except where R4 applies.
- R3: With PLL-on set, a write of source select = 1 is accepted even while lock reads 0, and `vco_sel` goes to 1.
- R4: Source select cannot be 1 while PLL-on is 0. A write that sets it with PLL-on = 0 is ignored, and clearing PLL-on also clears it.
- R5: The status word is at address 1. Bit 0 shows the lock input delayed by SYNC_STAGES clock edges, and it reads 0 while PLL-on is 0.
- R6: In automatic mode, a rise of the synchronized lock sets the flag (status bit 1) one edge after the lock bit changes.
- R7: In automatic mode, a fall of the synchronized lock also sets the flag.
- R8: The flag sets regardless of interrupt enable. `irq_req` is high exactly when the flag is set and interrupt enable is 1.
- R9: With automatic mode off, the flag reads 0, lock changes do not set it, `irq_req` stays 0, and a pending flag is discarded.
- R10: Writing status with bit 1 = 1 clears the flag. Writing bit 1 = 0 leaves it unchanged.
- R11: If a lock change and a clearing write land on the same edge, the flag ends up set.
- R12: Clearing source select while keeping PLL-on gives `pll_en` = 1 and `vco_sel` = 0. Clearing both gives `pll_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pll_lock_in | input | 1 | Asynchronous lock indication from the PLL |
| bus_addr | input | ADDR_W | Register select: 0 control, 1 status |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| pll_en | output | 1 | PLL power-on enable |
| vco_sel | output | 1 | Selects VCO/2 as the output clock source |
| irq_req | output | 1 | CPU interrupt request |

## Verification
The bench builds the block with its defaults: SYNC_STAGES = 2, an 8-bit data path and a 1-bit address. With only two synchronizer flops, the cycle where lock is visible but the flag is not yet set can be sampled exactly. A clearing write can also be placed on the very edge where a set arrives. Both directions of lock change are driven with automatic mode both on and off. The PLL is also switched off while lock is high, which shows that a gated lock never leaks into the flag when automatic mode is off.

// File: rtl/pll_irq_pkg.sv
package pll_irq_pkg;

  localparam int CTRL_ADDR = 0;
  localparam int STAT_ADDR = 1;

  localparam int B_PLLON = 0;
  localparam int B_SRC   = 1;
  localparam int B_IEN   = 2;
  localparam int B_AUTO  = 3;
  localparam int CTRL_BITS = 4;

  localparam int B_LOCK = 0;
  localparam int B_FLAG = 1;

  typedef struct packed {
    logic auto_md;
    logic irq_en;
    logic src_sel;
    logic pll_on;
  } ctrl_t;

  // lock changed between the current and previous sample
  function automatic logic lock_changed(logic cur, logic prev);
    return cur ^ prev;
  endfunction

  // next flag value: auto gate, then set wins over clear
  function automatic logic flag_next(logic auto_md, logic cur, logic set_ev, logic clr_ev);
    if (!auto_md) return 1'b0;
    if (set_ev)   return 1'b1;
    if (clr_ev)   return 1'b0;
    return cur;
  endfunction

  // source select may only stand while the PLL is on
  function automatic logic src_allowed(logic pll_on, logic req);
    return pll_on & req;
  endfunction

endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] stg;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= 1'b0;
          else        stg[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= 1'b0;
          else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/lock_edge_det.sv
module lock_edge_det
  import pll_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lock_s,
  input  logic pll_on,
  output logic lock_eff,
  output logic lock_edge
);
  logic lock_prev;

  assign lock_eff = lock_s & pll_on;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lock_prev <= 1'b0;
    else        lock_prev <= lock_eff;

  assign lock_edge = lock_changed(lock_eff, lock_prev);
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import pll_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ctrl,
  input  logic [CTRL_BITS-1:0] wbits,
  output ctrl_t                ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.pll_on  <= wbits[B_PLLON];
      ctrl_q.src_sel <= src_allowed(wbits[B_PLLON], wbits[B_SRC]);
      ctrl_q.irq_en  <= wbits[B_IEN];
      ctrl_q.auto_md <= wbits[B_AUTO];
    end
  end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import pll_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic auto_md,
  input  logic irq_en,
  input  logic lock_edge,
  input  logic clr_req,
  output logic flag_q,
  output logic irq_req
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(auto_md, flag_q, lock_edge, clr_req);

  assign irq_req = flag_q & irq_en & auto_md;
endmodule

// File: rtl/pll_lockirq_ctrl.sv
module pll_lockirq_ctrl
  import pll_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 1,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_lock_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pll_en,
  output logic              vco_sel,
  output logic              irq_req
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  ctrl_t ctrl_q;
  logic  lock_s, lock_eff, lock_edge, flag_q;
  logic  ctrl_wr, clr_req, auto_q, irq_en_q;
  logic  unused_wdata_hi;

  assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
  assign clr_req  = bus_wr && (bus_addr == A_STAT) && bus_wdata[B_FLAG];
  assign auto_q   = ctrl_q.auto_md;
  assign irq_en_q = ctrl_q.irq_en;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CTRL_BITS];

  lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pll_lock_in), .q_sync(lock_s)
  );

  lock_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .lock_s(lock_s), .pll_on(ctrl_q.pll_on),
    .lock_eff(lock_eff), .lock_edge(lock_edge)
  );

  ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(ctrl_wr),
    .wbits(bus_wdata[CTRL_BITS-1:0]), .ctrl_q(ctrl_q)
  );

  irq_flag_unit u_flag (
    .clk(clk), .rst_n(rst_n), .auto_md(ctrl_q.auto_md), .irq_en(ctrl_q.irq_en),
    .lock_edge(lock_edge), .clr_req(clr_req), .flag_q(flag_q), .irq_req(irq_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) begin
      bus_rdata[B_PLLON] = ctrl_q.pll_on;
      bus_rdata[B_SRC]   = ctrl_q.src_sel;
      bus_rdata[B_IEN]   = ctrl_q.irq_en;
      bus_rdata[B_AUTO]  = ctrl_q.auto_md;
    end else if (bus_addr == A_STAT) begin
      bus_rdata[B_LOCK]  = lock_eff;
      bus_rdata[B_FLAG]  = flag_q & ctrl_q.auto_md;
    end
  end

  assign pll_en  = ctrl_q.pll_on;
  assign vco_sel = ctrl_q.src_sel;
endmodule

// File: rtl/pll_irq_chk.sv
module pll_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic pll_en,
  input logic vco_sel,
  input logic irq_req,
  input logic auto_q,
  input logic irq_en_q,
  input logic flag_q,
  input logic lock_edge,
  input logic clr_req,
  input logic ctrl_wr
);
  AST_SRC_NEEDS_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    vco_sel |-> pll_en); // R4

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (flag_q && irq_en_q)); // R8

  AST_AUTO_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_q |=> !flag_q); // R9

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_edge && auto_q && !ctrl_wr) |=> flag_q); // R6

  AST_FLAG_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> ($past(clr_req) || !$past(auto_q))); // R10
endmodule

bind pll_lockirq_ctrl pll_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .vco_sel(vco_sel), .irq_req(irq_req),
  .auto_q(auto_q), .irq_en_q(irq_en_q), .flag_q(flag_q), .lock_edge(lock_edge),
  .clr_req(clr_req), .ctrl_wr(ctrl_wr)
);

// File: tb/tb_pll_lockirq_ctrl.sv
`timescale 1ns/1ps
module tb_pll_lockirq_ctrl;
  localparam int DW = 8;
  // control bits: 0 pll_on, 1 src, 2 irq_en, 3 auto; status: 0 lock, 1 flag
  localparam logic A_CTRL = 1'b0, A_STAT = 1'b1;

  logic clk = 0, rst_n = 0, lock_in = 0, bus_wr = 0;
  logic bus_addr = 0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic pll_en, vco_sel, irq_req;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    bit        outs;
    logic [7:0] exp;
    logic [7:0] mask;
    string     tag;
  } item_t;
  item_t sb[$];

  pll_lockirq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pll_lock_in(lock_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pll_en(pll_en), .vco_sel(vco_sel), .irq_req(irq_req)
  );

  always #4 clk = ~clk;

  // monitor: pops expected items a little after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb.pop_front();
        act = it.outs ? {5'b0, irq_req, vco_sel, pll_en} : bus_rdata;
        n_tests++;
        if ((act & it.mask) !== (it.exp & it.mask)) begin
          n_fail++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, act & it.mask, it.exp & it.mask);
        end
      end
    end
  end

  task automatic expect_reg(input logic a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.outs = 0; it.exp = e; it.mask = (a == A_CTRL) ? 8'h0F : 8'h03; it.tag = tag;
    sb.push_back(it);
  endtask

  // expected outputs as {irq_req, vco_sel, pll_en}
  task automatic expect_out(input logic [2:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.outs = 1; it.exp = {5'b0, e}; it.mask = 8'h07; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic set_lock(input logic v);
    @(negedge clk);
    lock_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    expect_reg(A_CTRL, 8'h00, "R1 ctrl after reset");
    expect_reg(A_STAT, 8'h00, "R1 status after reset");
    expect_out(3'b000, "R1 outputs after reset");

    wr(A_CTRL, 8'h02);
    expect_reg(A_CTRL, 8'h00, "R4 src write ignored with pll off");
    expect_out(3'b000, "R4 vco_sel stays low");

    wr(A_CTRL, 8'h03);
    expect_reg(A_CTRL, 8'h03, "R2 ctrl readback");
    expect_out(3'b011, "R3 src accepted with lock 0");

    wr(A_CTRL, 8'h01);
    expect_out(3'b001, "R12 disengaged, pll kept on");
    wr(A_CTRL, 8'h03);
    wr(A_CTRL, 8'h00);
    expect_out(3'b000, "R12 disengaged and off");
    expect_reg(A_CTRL, 8'h00, "R4 clearing pll_on clears src");

    // auto off: lock rise must not set the flag
    wr(A_CTRL, 8'h05);
    set_lock(1);
    idle(4);
    expect_reg(A_STAT, 8'h01, "R9 lock seen, no flag with auto off");
    expect_out(3'b001, "R9 no irq with auto off");
    wr(A_CTRL, 8'h04);
    expect_reg(A_STAT, 8'h00, "R5 lock reads 0 with pll off");
    wr(A_CTRL, 8'h05);
    idle(2);

    // auto on, irq disabled, falling lock
    wr(A_CTRL, 8'h09);
    expect_reg(A_CTRL, 8'h09, "R2 auto readback");
    set_lock(0);
    idle(3);
    expect_reg(A_STAT, 8'h02, "R7 fall sets flag");
    expect_out(3'b001, "R8 flag without irq_en gives no irq");
    wr(A_CTRL, 8'h0D);
    expect_out(3'b101, "R8 irq once enabled");

    wr(A_STAT, 8'h00);
    expect_reg(A_STAT, 8'h02, "R10 write 0 keeps flag");
    wr(A_STAT, 8'h02);
    expect_reg(A_STAT, 8'h00, "R10 write 1 clears flag");
    expect_out(3'b001, "R10 irq drops after clear");

    // rising lock, stage-accurate timing
    set_lock(1);
    idle(1);
    expect_reg(A_STAT, 8'h01, "R5 lock visible after sync");
    expect_reg(A_STAT, 8'h03, "R6 rise sets flag next edge");
    expect_out(3'b101, "R8 irq on rise");

    // set wins over a clear on the same edge
    wr(A_STAT, 8'h02);
    expect_reg(A_STAT, 8'h01, "R10 clear before collision");
    set_lock(0);
    idle(1);
    wr(A_STAT, 8'h02);
    expect_reg(A_STAT, 8'h02, "R11 set wins over clear");

    // turning auto off discards the flag
    wr(A_CTRL, 8'h05);
    expect_reg(A_STAT, 8'h00, "R9 flag reads 0 with auto off");
    expect_out(3'b001, "R9 irq low with auto off");
    wr(A_CTRL, 8'h0D);
    expect_reg(A_STAT, 8'h00, "R9 flag not restored");

    wr(A_CTRL, 8'h05);
    set_lock(1);
    idle(4);
    wr(A_CTRL, 8'h0D);
    expect_reg(A_STAT, 8'h01, "R9 change during auto off not latched");
    expect_out(3'b001, "R9 no irq afterwards");

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule